// File: doc/BRIEF.md
# Background Mosaic Pixel Replicator

This block sits in a tile-based video pipeline between the per-layer background pixel fetch and the layer compositor. For every background layer whose mosaic enable is set, each incoming pixel is replaced by the pixel found at the top-left corner of the square block that contains it. The image of that layer looks coarser. The block edge length is programmable from one to sixteen pixels. One size setting is shared by all background layers. Each layer has its own enable bit. The sprite pixel stream passes through on a matching delay so that it stays aligned with the background layers, and it is never altered.

The block takes one pixel per cycle while `pix_en` is high, together with the raster coordinates of that pixel. The x coordinate starts at 0 on each line and rises by one for every accepted pixel. Horizontal blocks are counted from x = 0 and vertical blocks from line y = 0. For each layer, a line buffer stores the block-head pixels of the top row of the current vertical block. Lower rows of the block are then rebuilt from that buffer without a new fetch. A held pixel keeps both its colour index (index 0 meaning transparent) and its priority bit.

Top module: `mosaic_bg`

## Requirements
- R1: `blk_size_m1` holds the block edge length minus one, so the value n gives blocks n+1 pixels wide and n+1 lines tall. With n = 0 every enabled layer output equals its input pixel.
- R2: Inside a block, the output at every column after the first equals the output of the block's first column on that line.
- R3: On every line of a vertical block after its top line, the output at a block's first column is the pixel that the layer supplied at the same block number on the top line. The layer's current input is not used.
- R4: Horizontal blocks restart at the pixel with x = 0 on every line. Vertical blocks restart at the line with y = 0.
- R5: The size is sampled only with the x = 0 pixel of a line, and values presented with other pixels are ignored. If the sampled size differs from the one used on the previous line, that line starts a new vertical block.
- R6: A layer whose bit in `lay_mos_en` is 0 outputs its input pixel unchanged. The bit is taken per pixel, and the single size setting applies to all enabled layers.
- R7: The sprite index and priority appear at the outputs unchanged, one cycle after they are presented with `pix_en` high.
- R8: Replicated pixels carry their priority bit and their index, including index 0 (transparent), exactly as captured.
- R9: Every output register is loaded one cycle after a cycle with `pix_en` high. `out_vld` is high exactly in those cycles. When `pix_en` is low, all pixel outputs hold their values and the block position does not advance.
- R10: While `rst` is high and in the cycle after it, `out_vld` and all pixel outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | A pixel is presented this cycle |
| ras_x | input | X_W | Horizontal position of the presented pixel |
| ras_y | input | Y_W | Line number of the presented pixel |
| blk_size_m1 | input | 4 | Block edge length minus one |
| lay_mos_en | input | NUM_LAYERS | Mosaic enable per background layer |
| bg_idx | input | NUM_LAYERS x IDX_W | Colour index per layer, 0 = transparent |
| bg_pri | input | NUM_LAYERS | Priority bit per layer |
| spr_idx | input | IDX_W | Sprite colour index |
| spr_pri | input | 1 | Sprite priority bit |
| out_vld | output | 1 | Outputs carry a freshly processed pixel |
| bg_idx_o | output | NUM_LAYERS x IDX_W | Processed colour index per layer |
| bg_pri_o | output | NUM_LAYERS | Processed priority per layer |
| spr_idx_o | output | IDX_W | Delayed sprite index |
| spr_pri_o | output | 1 | Delayed sprite priority |

## Verification
The assertions check, on every cycle, the properties that involve only adjacent cycles:
- the one-cycle valid timing and the holding of outputs while stalled;
- sprite pass-through;
- the unchanged output of disabled layers;
- the stability of an enabled layer across the non-first columns of a block;
- the horizontal phase never exceeding the sampled size.

Several behaviours can only be shown by the bench's scenarios, because they depend on history across whole lines:
- reuse of the top-line pixels on lower lines of a block;
- the line-start-only sampling of the size and the forced vertical restart on a size change;
- alignment of blocks to x = 0 and y = 0.

// File: rtl/mos_pkg.sv
package mos_pkg;

    localparam int IDX_W  = 8;
    localparam int SIZE_W = 4;

    typedef struct packed {
        logic             pri;
        logic [IDX_W-1:0] idx;
    } pix_t;

    // Advance a block phase; wraps to zero after reaching the size value.
    function automatic logic [SIZE_W-1:0] phase_step(input logic [SIZE_W-1:0] ph,
                                                    input logic [SIZE_W-1:0] sz);
        return (ph >= sz) ? '0 : ph + 1'b1;
    endfunction

    function automatic logic phase_wraps(input logic [SIZE_W-1:0] ph,
                                         input logic [SIZE_W-1:0] sz);
        return ph >= sz;
    endfunction

endpackage

// File: rtl/mos_phase.sv
module mos_phase
    import mos_pkg::*;
#(
    parameter int X_W   = 9,
    parameter int Y_W   = 9,
    parameter int BLK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_en,
    input  logic [X_W-1:0]    ras_x,
    input  logic [Y_W-1:0]    ras_y,
    input  logic [SIZE_W-1:0] size_in,
    output logic [SIZE_W-1:0] cur_xph,
    output logic [SIZE_W-1:0] cur_size,
    output logic              cur_top,
    output logic [BLK_W-1:0]  cur_blk
);

    logic [SIZE_W-1:0] size_r, xph_r, yph_r;
    logic [BLK_W-1:0]  blk_r;
    logic [SIZE_W-1:0] yph_c;
    logic              line_st;

    assign line_st = (ras_x == '0);

    always_comb begin
        if (line_st) begin
            cur_size = size_in;
            cur_xph  = '0;
            cur_blk  = '0;
            if (ras_y == '0 || size_in != size_r) begin
                yph_c = '0;
            end else begin
                yph_c = phase_step(yph_r, size_in);
            end
        end else begin
            cur_size = size_r;
            yph_c    = yph_r;
            if (phase_wraps(xph_r, size_r)) begin
                cur_xph = '0;
                cur_blk = blk_r + 1'b1;
            end else begin
                cur_xph = xph_r + 1'b1;
                cur_blk = blk_r;
            end
        end
    end

    assign cur_top = (yph_c == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            size_r <= '0;
            xph_r  <= '0;
            yph_r  <= '0;
            blk_r  <= '0;
        end else if (pix_en) begin
            size_r <= cur_size;
            xph_r  <= cur_xph;
            yph_r  <= yph_c;
            blk_r  <= cur_blk;
        end
    end

endmodule

// File: rtl/mos_layer.sv
module mos_layer
    import mos_pkg::*;
#(
    parameter int LINE_W = 256,
    parameter int BLK_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_en,
    input  logic             mos_en,
    input  pix_t             raw,
    input  logic             head_col,
    input  logic             top_row,
    input  logic [BLK_W-1:0] blk,
    output pix_t             pix_o
);

    pix_t line_buf [LINE_W];
    pix_t hold_q;
    pix_t head;

    assign head = top_row ? raw : line_buf[blk];

    always_ff @(posedge clk) begin
        if (pix_en && top_row && head_col) begin
            line_buf[blk] <= raw;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            pix_o  <= '0;
        end else if (pix_en) begin
            if (head_col) begin
                hold_q <= head;
            end
            if (!mos_en) begin
                pix_o <= raw;
            end else if (head_col) begin
                pix_o <= head;
            end else begin
                pix_o <= hold_q;
            end
        end
    end

endmodule

// File: rtl/mosaic_bg.sv
module mosaic_bg
    import mos_pkg::*;
#(
    parameter int NUM_LAYERS = 4,
    parameter int LINE_W     = 256,
    parameter int X_W        = 9,
    parameter int Y_W        = 9
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                pix_en,
    input  logic [X_W-1:0]                      ras_x,
    input  logic [Y_W-1:0]                      ras_y,
    input  logic [SIZE_W-1:0]                   blk_size_m1,
    input  logic [NUM_LAYERS-1:0]               lay_mos_en,
    input  logic [NUM_LAYERS-1:0][IDX_W-1:0]    bg_idx,
    input  logic [NUM_LAYERS-1:0]               bg_pri,
    input  logic [IDX_W-1:0]                    spr_idx,
    input  logic                                spr_pri,
    output logic                                out_vld,
    output logic [NUM_LAYERS-1:0][IDX_W-1:0]    bg_idx_o,
    output logic [NUM_LAYERS-1:0]               bg_pri_o,
    output logic [IDX_W-1:0]                    spr_idx_o,
    output logic                                spr_pri_o
);

    localparam int BLK_W = (LINE_W > 1) ? $clog2(LINE_W) : 1;

    logic [SIZE_W-1:0] ph_xph;
    logic [SIZE_W-1:0] ph_size;
    logic              ph_top;
    logic [BLK_W-1:0]  ph_blk;

    mos_phase #(.X_W(X_W), .Y_W(Y_W), .BLK_W(BLK_W)) i_phase (
        .clk      (clk),
        .rst      (rst),
        .pix_en   (pix_en),
        .ras_x    (ras_x),
        .ras_y    (ras_y),
        .size_in  (blk_size_m1),
        .cur_xph  (ph_xph),
        .cur_size (ph_size),
        .cur_top  (ph_top),
        .cur_blk  (ph_blk)
    );

    for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_layer
        pix_t raw_g, out_g;
        assign raw_g = '{pri: bg_pri[g], idx: bg_idx[g]};

        mos_layer #(.LINE_W(LINE_W), .BLK_W(BLK_W)) i_layer (
            .clk      (clk),
            .rst      (rst),
            .pix_en   (pix_en),
            .mos_en   (lay_mos_en[g]),
            .raw      (raw_g),
            .head_col (ph_xph == '0),
            .top_row  (ph_top),
            .blk      (ph_blk),
            .pix_o    (out_g)
        );

        assign bg_idx_o[g] = out_g.idx;
        assign bg_pri_o[g] = out_g.pri;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld   <= 1'b0;
            spr_idx_o <= '0;
            spr_pri_o <= 1'b0;
        end else begin
            out_vld <= pix_en;
            if (pix_en) begin
                spr_idx_o <= spr_idx;
                spr_pri_o <= spr_pri;
            end
        end
    end

endmodule

// File: rtl/mos_chk.sv
module mos_chk
    import mos_pkg::*;
#(
    parameter int NL = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        pix_en,
    input logic [NL-1:0]               lay_mos_en,
    input logic [NL-1:0][IDX_W-1:0]    bg_idx,
    input logic [NL-1:0]               bg_pri,
    input logic [IDX_W-1:0]            spr_idx,
    input logic                        spr_pri,
    input logic                        out_vld,
    input logic [NL-1:0][IDX_W-1:0]    bg_idx_o,
    input logic [NL-1:0]               bg_pri_o,
    input logic [IDX_W-1:0]            spr_idx_o,
    input logic                        spr_pri_o,
    input logic [SIZE_W-1:0]           xph,
    input logic [SIZE_W-1:0]           size_now
);

    // R9
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        pix_en |=> out_vld);

    // R9
    vld_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> (!out_vld && $stable(bg_idx_o) && $stable(bg_pri_o) && $stable(spr_idx_o)));

    // R10
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_vld && bg_idx_o == '0 && bg_pri_o == '0 && spr_idx_o == '0 && !spr_pri_o));

    // R7
    spr_pass_chk: assert property (@(posedge clk) disable iff (rst)
        pix_en |=> (spr_idx_o == $past(spr_idx) && spr_pri_o == $past(spr_pri)));

    // R1
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        pix_en |-> xph <= size_now);

    for (genvar g = 0; g < NL; g++) begin : g_chk
        // R6
        off_pass_chk: assert property (@(posedge clk) disable iff (rst)
            (pix_en && !lay_mos_en[g]) |=>
                (bg_idx_o[g] == $past(bg_idx[g]) && bg_pri_o[g] == $past(bg_pri[g])));

        // R2
        repeat_col_chk: assert property (@(posedge clk) disable iff (rst)
            (pix_en && lay_mos_en[g] && xph != '0) |=>
                ($stable(bg_idx_o[g]) && $stable(bg_pri_o[g])));
    end

endmodule

bind mosaic_bg mos_chk #(.NL(NUM_LAYERS)) i_mos_chk (
    .clk        (clk),
    .rst        (rst),
    .pix_en     (pix_en),
    .lay_mos_en (lay_mos_en),
    .bg_idx     (bg_idx),
    .bg_pri     (bg_pri),
    .spr_idx    (spr_idx),
    .spr_pri    (spr_pri),
    .out_vld    (out_vld),
    .bg_idx_o   (bg_idx_o),
    .bg_pri_o   (bg_pri_o),
    .spr_idx_o  (spr_idx_o),
    .spr_pri_o  (spr_pri_o),
    .xph        (ph_xph),
    .size_now   (ph_size)
);

// File: tb/test_mosaic_bg.sv
module test_mosaic_bg;

    localparam int NL = 4;
    localparam int IW = 8;
    localparam int LW = 256;

    logic                   clk = 1'b0;
    logic                   rst;
    logic                   pix_en;
    logic [8:0]             ras_x;
    logic [8:0]             ras_y;
    logic [3:0]             blk_size_m1;
    logic [NL-1:0]          lay_mos_en;
    logic [NL-1:0][IW-1:0]  bg_idx;
    logic [NL-1:0]          bg_pri;
    logic [IW-1:0]          spr_idx;
    logic                   spr_pri;
    logic                   out_vld;
    logic [NL-1:0][IW-1:0]  bg_idx_o;
    logic [NL-1:0]          bg_pri_o;
    logic [IW-1:0]          spr_idx_o;
    logic                   spr_pri_o;

    mosaic_bg #(.NUM_LAYERS(NL), .LINE_W(LW)) i_mosaic_bg (.*);

    always #5 clk = ~clk;

    int total = 0;
    int bad   = 0;

    // Reference state, built from the requirements.
    int         m_size, m_xph, m_yph, m_blk;
    logic [8:0] m_buf  [NL][LW];
    logic [8:0] m_hold [NL];
    logic [8:0] exp_l  [NL];
    string      exp_tag[NL];
    logic [8:0] exp_spr;
    logic       exp_vld;
    bit         have_exp;

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        if (!have_exp) return;
        chk("R9 out_vld", {8'd0, out_vld}, {8'd0, exp_vld});
        chk("R7 sprite", {spr_pri_o, spr_idx_o}, exp_spr);
        for (int l = 0; l < NL; l++)
            chk(exp_tag[l], {bg_pri_o[l], bg_idx_o[l]}, exp_l[l]);
    endtask

    task automatic model_pixel(input int x, input int y, input int sz);
        logic [8:0] raw, head;
        if (x == 0) begin
            // R4 / R5: restart horizontal, vertical on y==0 or size change
            if (y == 0 || sz != m_size) m_yph = 0;
            else m_yph = (m_yph >= sz) ? 0 : m_yph + 1;
            m_size = sz; m_xph = 0; m_blk = 0;
        end else if (m_xph >= m_size) begin
            m_xph = 0; m_blk = m_blk + 1;
        end else begin
            m_xph = m_xph + 1;
        end
        for (int l = 0; l < NL; l++) begin
            raw  = {bg_pri[l], bg_idx[l]};
            head = (m_yph == 0) ? raw : m_buf[l][m_blk % LW];
            if (m_yph == 0 && m_xph == 0) m_buf[l][m_blk % LW] = raw;
            if (!lay_mos_en[l]) begin
                exp_l[l] = raw; exp_tag[l] = "R6 disabled layer";
            end else if (m_xph == 0) begin
                exp_l[l] = head;
                exp_tag[l] = (m_size == 0) ? "R1 size one" :
                             (m_yph != 0) ? "R3 lower row reuse" :
                             (head[7:0] == 0) ? "R8 transparent head" : "R4 block head";
            end else begin
                exp_l[l] = m_hold[l];
                exp_tag[l] = (m_hold[l][7:0] == 0) ? "R8 held transparent" : "R2 column repeat";
            end
            if (m_xph == 0) m_hold[l] = head;
        end
        exp_spr = {spr_pri, spr_idx};
    endtask

    task automatic step(input bit pe, input int x, input int y, input int sz);
        @(negedge clk);
        check_outputs();
        pix_en      = pe;
        ras_x       = pe ? 9'(x) : 9'($urandom);
        ras_y       = 9'(y);
        blk_size_m1 = 4'(sz);
        for (int l = 0; l < NL; l++) begin
            bg_idx[l] = ($urandom % 4 == 0) ? 8'd0 : 8'($urandom);
            bg_pri[l] = 1'($urandom);
        end
        spr_idx = 8'($urandom);
        spr_pri = 1'($urandom);
        if (pe) model_pixel(x, y, sz);
        exp_vld  = pe;
        have_exp = 1'b1;
    endtask

    // opts: bit0 stalls, bit1 size change per line, bit2 mid-line size noise
    task automatic run_frame(input int lines, input int width, input int base_sz,
                             input int opts, input bit rand_en);
        int sz_line;
        for (int y = 0; y < lines; y++) begin
            sz_line = (opts & 2) ? (($urandom % 3 == 0) ? int'($urandom % 16) : m_size) : base_sz;
            if (rand_en) lay_mos_en = 4'($urandom);
            for (int x = 0; x < width; x++) begin
                if ((opts & 1) && $urandom % 5 == 0) step(0, 0, y, $urandom % 16);
                // R5: non-zero x carries noise on the size input when bit2 set
                step(1, x, y, (x == 0) ? sz_line : ((opts & 4) ? int'($urandom % 16) : sz_line));
            end
            for (int b = 0; b < 3; b++) step(0, 0, y, $urandom % 16);
        end
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL R9 watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        have_exp = 0; m_size = 0; m_xph = 0; m_yph = 0; m_blk = 0;
        for (int l = 0; l < NL; l++) begin
            m_hold[l] = '0;
            for (int i = 0; i < LW; i++) m_buf[l][i] = '0;
        end
        rst = 1; pix_en = 0; ras_x = 0; ras_y = 0; blk_size_m1 = 0;
        lay_mos_en = '1; bg_idx = '0; bg_pri = '0; spr_idx = 0; spr_pri = 0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset vld", {8'd0, out_vld}, 9'd0);
        for (int l = 0; l < NL; l++) chk("R10 reset pix", {bg_pri_o[l], bg_idx_o[l]}, 9'd0);
        chk("R10 reset sprite", {spr_pri_o, spr_idx_o}, 9'd0);
        rst = 0;

        run_frame(6, 32, 0, 0, 0);        // R1: size value 0, no effect
        run_frame(10, 40, 3, 1, 1);       // R2 R3 R9: stalls, random enables
        run_frame(20, 48, 15, 0, 0);      // R4 R3: largest block
        run_frame(12, 40, 2, 6, 0);       // R5: line-start changes, mid-line noise
        lay_mos_en = '0;
        run_frame(4, 24, 5, 0, 0);        // R6: all layers disabled
        run_frame(8, 36, 1, 0, 1);        // R6: mixed enables, shared size
        for (int f = 0; f < 5; f++)
            run_frame(12, 20 + int'($urandom % 40), int'($urandom % 16), 7, 1);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule